// File: doc/BRIEF.md
# Element-Width Partitioned Slice Adder

This block adds two packed SIMD operands whose lane count is chosen at run time. A 2-bit element-width code splits the 16-bit first operand into one 16-bit lane, two 8-bit lanes or four 4-bit lanes. The second operand is only 8 bits wide and stays packed. Before the add it is spread into the lane positions of the first operand.

In the default slice mode, only the low 3 bits of each lane of the first operand take part. Each lane receives one 2-bit element of the second operand. The carry chain is cut at every lane boundary. It is also cut just above each 3-bit slice, so the padding bits above the slice stay zero. In fixed mode, each lane adds across its full width. The second operand is then divided evenly by the lane count, so its elements are 8, 4 or 2 bits wide. In both modes, the carry leaving each lane goes to that lane's overflow flag and never reaches the next lane. The result, the overflow flags and a valid flag are registered once.

Top module: `slice_lane_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `out_sum` and `out_ovf` all become zero, whatever the other inputs are.
- R2: `out_valid` equals the `in_valid` value sampled at the previous rising edge.
- R3: Slice mode (`fixed_mode`=0) sets the lane count N from `elwid`: 00 gives N=1, 01 gives N=2, 10 gives N=4. The lane width is L=16/N and the element stride is S=8/N. For each lane k below N, `out_sum[L*k+2:L*k]` equals the low 3 bits of `op_a[L*k+2:L*k] + op_b[S*k+1:S*k]`.
- R4: In slice mode, every `out_sum` bit outside the 3-bit result fields is zero.
- R5: In slice mode, `out_ovf[k]` is the carry out of lane k's 3-bit add. That carry never changes any bit of another lane.
- R6: Fixed mode (`fixed_mode`=1) adds each full L-bit lane k of `op_a` to the zero-extended S-bit element `op_b[S*k+S-1:S*k]`. The sum is written to `out_sum[L*k+L-1:L*k]` modulo 2^L.
- R7: In fixed mode, `out_ovf[k]` is the carry out of the top bit of lane k. That carry does not enter lane k+1.
- R8: Bits of `out_ovf` at index N or above are zero.
- R9: `elwid` = 11 gives exactly the same outputs as `elwid` = 10.
- R10: When `in_valid` is low at a rising edge, `out_sum` and `out_ovf` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| elwid | input | 2 | Element-width code (00/01/10, 11 treated as 10) |
| fixed_mode | input | 1 | 1 selects full-lane add with evenly split second operand |
| op_a | input | 16 | First operand, lane-partitioned |
| op_b | input | 8 | Second operand, packed elements |
| out_valid | output | 1 | Registered valid flag |
| out_sum | output | 16 | Registered lane-positioned sum |
| out_ovf | output | 4 | Registered per-lane carry-out flags |

## Verification
Directed operands of all ones show the difference between a carry that stops at a partition point and one that leaks into padding or into the neighbouring lane. The ones in the first operand are paired with a second operand of zeros or of small per-element values. Mixed per-lane values under each width code show whether the second operand is spread with the right stride for that mode. Code 11 is replayed against code 10 with the same operands, and cycles with valid low are checked for a held result. Seeded random operands, codes, modes and valid strobes then cover the remaining combinations against a bench-side lane model.

// File: rtl/slice_add_pkg.sv
`timescale 1ns/1ps
package slice_add_pkg;
   localparam int unsigned SEL_W        = 2;
   localparam int unsigned DEF_DATA_W   = 16;
   localparam int unsigned DEF_B_W      = 8;
   localparam int unsigned DEF_SLICE_W  = 3;
   localparam int unsigned DEF_BELEM_W  = 2;
   localparam int unsigned DEF_NUM_CFG  = 3;

   typedef enum logic [SEL_W-1:0] {
      EW_LANES1 = 2'b00,
      EW_LANES2 = 2'b01,
      EW_LANES4 = 2'b10,
      EW_RSVD   = 2'b11
   } ew_code_e;
endpackage

// File: rtl/sa_part_ctrl.sv
`timescale 1ns/1ps
// Produces the carry-break mask: bit i set means no carry enters bit i.
module sa_part_ctrl
   import slice_add_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned SLICE_W = DEF_SLICE_W,
   parameter int unsigned NUM_CFG = DEF_NUM_CFG
) (
   input  logic [SEL_W-1:0]  cfg,
   input  logic              fixed_mode,
   output logic [DATA_W-1:0] brk
);
   wire [DATA_W-1:0] brk_slc [NUM_CFG];
   wire [DATA_W-1:0] brk_fix [NUM_CFG];

   for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
      localparam int unsigned LW = DATA_W >> c;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         // lane boundary in both modes, slice/padding seam only in slice mode
         assign brk_fix[c][i] = ((i % LW) == 0);
         assign brk_slc[c][i] = ((i % LW) == 0) || ((i % LW) == SLICE_W);
      end
   end

   always_comb begin
      brk = '0;
      for (int c = 0; c < NUM_CFG; c++) begin
         if (cfg == SEL_W'(c)) begin
            brk = fixed_mode ? brk_fix[c] : brk_slc[c];
         end
      end
   end
endmodule

// File: rtl/sa_operand_spread.sv
`timescale 1ns/1ps
// Places both operands at lane positions for the selected width and mode.
module sa_operand_spread
   import slice_add_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned B_W     = DEF_B_W,
   parameter int unsigned SLICE_W = DEF_SLICE_W,
   parameter int unsigned BELEM_W = DEF_BELEM_W,
   parameter int unsigned NUM_CFG = DEF_NUM_CFG
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [B_W-1:0]    op_b,
   input  logic [SEL_W-1:0]  cfg,
   input  logic              fixed_mode,
   output logic [DATA_W-1:0] a_pos,
   output logic [DATA_W-1:0] b_pos
);
   wire [DATA_W-1:0] a_slc [NUM_CFG];
   wire [DATA_W-1:0] b_slc [NUM_CFG];
   wire [DATA_W-1:0] a_fix [NUM_CFG];
   wire [DATA_W-1:0] b_fix [NUM_CFG];

   for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
      localparam int unsigned NL = 1 << c;
      localparam int unsigned LW = DATA_W / NL;
      localparam int unsigned SW = B_W / NL;
      for (genvar k = 0; k < NL; k++) begin : g_lane
         // slice mode: narrow field of A, one small packed element of B
         assign a_slc[c][LW*k +: LW] = {{(LW-SLICE_W){1'b0}}, op_a[LW*k +: SLICE_W]};
         assign b_slc[c][LW*k +: LW] = {{(LW-BELEM_W){1'b0}}, op_b[SW*k +: BELEM_W]};
         // fixed mode: whole lane of A, evenly split B zero-extended
         assign a_fix[c][LW*k +: LW] = op_a[LW*k +: LW];
         assign b_fix[c][LW*k +: LW] = {{(LW-SW){1'b0}}, op_b[SW*k +: SW]};
      end
   end

   always_comb begin
      a_pos = '0;
      b_pos = '0;
      for (int c = 0; c < NUM_CFG; c++) begin
         if (cfg == SEL_W'(c)) begin
            a_pos = fixed_mode ? a_fix[c] : a_slc[c];
            b_pos = fixed_mode ? b_fix[c] : b_slc[c];
         end
      end
   end
endmodule

// File: rtl/sa_part_adder.sv
`timescale 1ns/1ps
// Ripple adder whose carry chain is cut wherever brk is set.
module sa_part_adder #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] brk,
   output logic [DATA_W-1:0] sum,
   output logic [DATA_W-1:0] cout
);
   wire [DATA_W-1:0] cin;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign cin[i] = 1'b0;
      end else begin : g_up
         assign cin[i] = brk[i] ? 1'b0 : cout[i-1];
      end
      assign sum[i]  = a[i] ^ b[i] ^ cin[i];
      assign cout[i] = (a[i] & b[i]) | (cin[i] & (a[i] ^ b[i]));
   end
endmodule

// File: rtl/sa_lane_flags.sv
`timescale 1ns/1ps
// Picks each active lane's carry-out from the bit that ends its add.
module sa_lane_flags
   import slice_add_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned SLICE_W = DEF_SLICE_W,
   parameter int unsigned NUM_CFG = DEF_NUM_CFG,
   localparam int unsigned LANES  = 1 << (NUM_CFG - 1)
) (
   input  logic [DATA_W-1:0] cout,
   input  logic [SEL_W-1:0]  cfg,
   input  logic              fixed_mode,
   output logic [LANES-1:0]  ovf
);
   wire [LANES-1:0] ovf_slc [NUM_CFG];
   wire [LANES-1:0] ovf_fix [NUM_CFG];
   logic            unused_cout;

   assign unused_cout = ^cout;

   for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
      localparam int unsigned NL = 1 << c;
      localparam int unsigned LW = DATA_W / NL;
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         if (k < NL) begin : g_on
            assign ovf_slc[c][k] = cout[LW*k + SLICE_W - 1];
            assign ovf_fix[c][k] = cout[LW*k + LW - 1];
         end else begin : g_off
            assign ovf_slc[c][k] = 1'b0;
            assign ovf_fix[c][k] = 1'b0;
         end
      end
   end

   always_comb begin
      ovf = '0;
      for (int c = 0; c < NUM_CFG; c++) begin
         if (cfg == SEL_W'(c)) begin
            ovf = fixed_mode ? ovf_fix[c] : ovf_slc[c];
         end
      end
   end
endmodule

// File: rtl/slice_lane_adder.sv
`timescale 1ns/1ps
module slice_lane_adder
   import slice_add_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned B_W     = DEF_B_W,
   parameter int unsigned SLICE_W = DEF_SLICE_W,
   parameter int unsigned BELEM_W = DEF_BELEM_W,
   parameter int unsigned NUM_CFG = DEF_NUM_CFG,
   localparam int unsigned LANES  = 1 << (NUM_CFG - 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [SEL_W-1:0]  elwid,
   input  logic              fixed_mode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [B_W-1:0]    op_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_sum,
   output logic [LANES-1:0]  out_ovf
);
   localparam int unsigned MIN_LANE_W = DATA_W >> (NUM_CFG - 1);
   localparam int unsigned MIN_ELEM_W = B_W >> (NUM_CFG - 1);

   initial begin : p_param_chk
      assert (NUM_CFG >= 1 && NUM_CFG <= (1 << SEL_W))
         else $fatal(1, "NUM_CFG out of range");
      assert (DATA_W % (1 << (NUM_CFG - 1)) == 0 && B_W % (1 << (NUM_CFG - 1)) == 0)
         else $fatal(1, "operand widths must split evenly into lanes");
      assert (MIN_LANE_W > SLICE_W && SLICE_W >= BELEM_W && SLICE_W >= 1)
         else $fatal(1, "slice must leave room for a partition point");
      assert (MIN_ELEM_W >= BELEM_W && DATA_W > B_W)
         else $fatal(1, "second operand element does not fit");
   end

   logic [SEL_W-1:0]  cfg;
   logic [DATA_W-1:0] brk;
   logic [DATA_W-1:0] a_pos;
   logic [DATA_W-1:0] b_pos;
   logic [DATA_W-1:0] sum_c;
   logic [DATA_W-1:0] cout_c;
   logic [LANES-1:0]  ovf_c;

   // codes past the last configuration fold onto it
   assign cfg = (elwid > SEL_W'(NUM_CFG - 1)) ? SEL_W'(NUM_CFG - 1) : elwid;

   sa_part_ctrl #(
      .DATA_W (DATA_W), .SLICE_W (SLICE_W), .NUM_CFG (NUM_CFG)
   ) i_ctrl (
      .cfg (cfg), .fixed_mode (fixed_mode), .brk (brk)
   );

   sa_operand_spread #(
      .DATA_W (DATA_W), .B_W (B_W), .SLICE_W (SLICE_W),
      .BELEM_W (BELEM_W), .NUM_CFG (NUM_CFG)
   ) i_spread (
      .op_a (op_a), .op_b (op_b), .cfg (cfg), .fixed_mode (fixed_mode),
      .a_pos (a_pos), .b_pos (b_pos)
   );

   sa_part_adder #(
      .DATA_W (DATA_W)
   ) i_adder (
      .a (a_pos), .b (b_pos), .brk (brk), .sum (sum_c), .cout (cout_c)
   );

   sa_lane_flags #(
      .DATA_W (DATA_W), .SLICE_W (SLICE_W), .NUM_CFG (NUM_CFG)
   ) i_flags (
      .cout (cout_c), .cfg (cfg), .fixed_mode (fixed_mode), .ovf (ovf_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_sum   <= '0;
         out_ovf   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sum <= sum_c;
            out_ovf <= ovf_c;
         end
      end
   end
endmodule

// File: rtl/sa_checker.sv
`timescale 1ns/1ps
module sa_checker
   import slice_add_pkg::*;
#(
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned B_W     = DEF_B_W,
   parameter int unsigned SLICE_W = DEF_SLICE_W,
   parameter int unsigned BELEM_W = DEF_BELEM_W,
   parameter int unsigned NUM_CFG = DEF_NUM_CFG,
   localparam int unsigned LANES  = 1 << (NUM_CFG - 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [SEL_W-1:0]  elwid,
   input logic              fixed_mode,
   input logic [DATA_W-1:0] op_a,
   input logic [B_W-1:0]    op_b,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_sum,
   input logic [LANES-1:0]  out_ovf
);
   localparam int unsigned HALF_W = DATA_W / 2;

   logic [SLICE_W:0] lane0_slc;
   logic [DATA_W:0]  lane0_full;

   assign lane0_slc  = (SLICE_W+1)'(op_a[SLICE_W-1:0]) + (SLICE_W+1)'(op_b[BELEM_W-1:0]);
   assign lane0_full = (DATA_W+1)'(op_a) + (DATA_W+1)'(op_b);

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && out_sum == '0 && out_ovf == '0));

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (out_valid == $past(in_valid)));

   // single-lane slice: low field and its carry come from bits 2:0 and 1:0
   assert_lane0_slice_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !fixed_mode && elwid == 2'b00)
      |=> (out_sum[SLICE_W-1:0] == $past(lane0_slc[SLICE_W-1:0])));

   assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !fixed_mode && elwid == 2'b00)
      |=> (out_sum[DATA_W-1:SLICE_W] == '0));

   assert_pad_zero_two_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !fixed_mode && elwid == 2'b01)
      |=> (out_sum[HALF_W-1:SLICE_W] == '0 && out_sum[DATA_W-1:HALF_W+SLICE_W] == '0));

   assert_lane0_carry_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !fixed_mode && elwid == 2'b00)
      |=> (out_ovf[0] == $past(lane0_slc[SLICE_W])));

   assert_full_carry_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && fixed_mode && elwid == 2'b00)
      |=> (out_ovf[0] == $past(lane0_full[DATA_W]) && out_sum == $past(lane0_full[DATA_W-1:0])));

   assert_idle_lanes_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && elwid == 2'b00) |=> (out_ovf[LANES-1:1] == '0));

   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_sum) && $stable(out_ovf)));
endmodule

bind slice_lane_adder sa_checker #(
   .DATA_W (DATA_W), .B_W (B_W), .SLICE_W (SLICE_W),
   .BELEM_W (BELEM_W), .NUM_CFG (NUM_CFG)
) i_sa_checker (
   .clk (clk), .rst (rst), .in_valid (in_valid), .elwid (elwid),
   .fixed_mode (fixed_mode), .op_a (op_a), .op_b (op_b),
   .out_valid (out_valid), .out_sum (out_sum), .out_ovf (out_ovf)
);

// File: tb/test_slice_lane_adder.sv
`timescale 1ns/1ps
module test_slice_lane_adder;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [1:0]  elwid;
   logic        fixed_mode;
   logic [15:0] op_a;
   logic [7:0]  op_b;
   logic        out_valid;
   logic [15:0] out_sum;
   logic [3:0]  out_ovf;

   int unsigned checks = 0;
   int unsigned fails  = 0;
   logic [15:0] exp_sum = '0;
   logic [3:0]  exp_ovf = '0;

   always #5 clk = ~clk;

   slice_lane_adder i_slice_lane_adder (
      .clk (clk), .rst (rst), .in_valid (in_valid), .elwid (elwid),
      .fixed_mode (fixed_mode), .op_a (op_a), .op_b (op_b),
      .out_valid (out_valid), .out_sum (out_sum), .out_ovf (out_ovf)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int unsigned lanes_of(logic [1:0] ew);
      return (ew == 2'b00) ? 1 : (ew == 2'b01) ? 2 : 4;
   endfunction

   // lane model: {ovf[3:0], sum[15:0]}
   function automatic logic [19:0] model(logic [15:0] a, logic [7:0] b,
                                         logic [1:0] ew, logic fm);
      int unsigned n, lw, sw, av, bv, s;
      logic [15:0] sm;
      logic [3:0]  ov;
      n = lanes_of(ew); lw = 16 / n; sw = 8 / n;
      sm = '0; ov = '0;
      for (int k = 0; k < n; k++) begin
         if (fm) begin
            av = (32'(a) >> (lw*k)) & ((32'd1 << lw) - 1);
            bv = (32'(b) >> (sw*k)) & ((32'd1 << sw) - 1);
            s  = av + bv;
            sm = sm | 16'((s & ((32'd1 << lw) - 1)) << (lw*k));
            ov[k] = ((s >> lw) & 1) != 0;
         end else begin
            av = (32'(a) >> (lw*k)) & 7;
            bv = (32'(b) >> (sw*k)) & 3;
            s  = av + bv;
            sm = sm | 16'((s & 7) << (lw*k));
            ov[k] = (s >> 3) != 0;
         end
      end
      return {ov, sm};
   endfunction

   function automatic logic [15:0] slice_mask(logic [1:0] ew);
      int unsigned n, lw;
      logic [15:0] m;
      n = lanes_of(ew); lw = 16 / n; m = '0;
      for (int k = 0; k < n; k++) m = m | 16'(32'd7 << (lw*k));
      return m;
   endfunction

   task automatic run(logic v, logic [1:0] ew, logic fm, logic [15:0] a, logic [7:0] b);
      string rs, ro;
      @(negedge clk);
      in_valid = v; elwid = ew; fixed_mode = fm; op_a = a; op_b = b;
      @(posedge clk);
      #1;
      if (v) {exp_ovf, exp_sum} = model(a, b, ew, fm);
      rs = fm ? "R6" : "R3";
      ro = fm ? "R7" : "R5";
      if (ew == 2'b11) begin rs = "R9"; ro = "R9"; end
      if (!v) begin rs = "R10"; ro = "R10"; end
      check("R2", "valid", 32'(out_valid), 32'(v));
      check(rs, "sum", 32'(out_sum), 32'(exp_sum));
      check(ro, "ovf", 32'(out_ovf), 32'(exp_ovf));
      if (v) begin
         check("R8", "idle lane ovf", 32'(out_ovf) >> lanes_of(ew), 32'd0);
         if (!fm) check("R4", "padding", 32'(out_sum & ~slice_mask(ew)), 32'd0);
      end
   endtask

   task automatic reset_check();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1; elwid = 2'b10; fixed_mode = 1'b1;
      op_a = 16'hFFFF; op_b = 8'hFF;
      @(posedge clk); #1;
      check("R1", "valid", 32'(out_valid), 32'd0);
      check("R1", "sum", 32'(out_sum), 32'd0);
      check("R1", "ovf", 32'(out_ovf), 32'd0);
      @(negedge clk);
      rst = 1'b0; in_valid = 1'b0;
      exp_sum = '0; exp_ovf = '0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin : p_watchdog
      #(100_000 * 10);
      fails++;
      $display("FAIL watchdog run did not complete");
      finish_run();
   end

   initial begin : p_main
      rst = 1'b1; in_valid = 1'b0; elwid = '0; fixed_mode = 1'b0;
      op_a = '0; op_b = '0;
      repeat (3) @(posedge clk);
      reset_check();

      // slice mode, one lane: 7+3 wraps, carry flagged, padding stays zero
      run(1'b1, 2'b00, 1'b0, 16'hFFFF, 8'hFF);
      // two lanes: 5+3 and 7+1 both wrap, stride 4 picks B[5:4]
      run(1'b1, 2'b01, 1'b0, 16'h0705, 8'h13);
      // four lanes, no carries
      run(1'b1, 2'b10, 1'b0, 16'hFFFF, 8'h00);
      // four lanes, every slice overflows
      run(1'b1, 2'b10, 1'b0, 16'h7777, 8'hFF);
      // fixed mode, each 4-bit lane wraps to zero
      run(1'b1, 2'b10, 1'b1, 16'hFFFF, 8'h55);
      // fixed mode, one lane, no carry then carry
      run(1'b1, 2'b00, 1'b1, 16'hFF00, 8'hFF);
      run(1'b1, 2'b00, 1'b1, 16'hFFFF, 8'h01);
      // fixed mode, two lanes, low lane carry must not reach high lane
      run(1'b1, 2'b01, 1'b1, 16'h00FF, 8'h01);
      // reserved code against code 10
      run(1'b1, 2'b11, 1'b0, 16'h7777, 8'hFF);
      run(1'b1, 2'b11, 1'b1, 16'hFFFF, 8'h55);
      // idle cycles with changed operands
      run(1'b0, 2'b01, 1'b1, 16'h1234, 8'hAB);
      run(1'b0, 2'b00, 1'b0, 16'hFFFF, 8'hFF);

      void'($urandom(32'h5A17));
      for (int i = 0; i < 400; i++) begin
         logic        v;
         logic [1:0]  ew;
         logic        fm;
         v  = ($urandom % 4) != 0;
         ew = 2'($urandom % 4);
         fm = 1'($urandom % 2);
         run(v, ew, fm, 16'($urandom), 8'($urandom));
      end

      reset_check();
      finish_run();
   end
endmodule